// File: doc/BRIEF.md
# Two-Wire Bus Activity Watchdog

This block is a passive watchdog that listens to the data and clock lines of a two-wire serial bus. It uses that traffic as proof that the host processor is still running. It never drives the bus. A timeout counter runs on the system clock. A complete bus framing clears the counter: a start condition, then at least one clock low phase, then a clock high phase, then a stop condition. If the counter reaches the selected terminal value first, the watchdog output goes high and stays high.

A two-bit period field chooses the timeout. The field is loaded through a single-cycle write strobe with a data word. Three codes select three counter lengths, given as parameters. The fourth code switches the watchdog off. Any write to the field also restarts the count from zero.

Top module: `wdg_bus_watchdog`

## Requirements
- R1: Once reset is released, the watchdog output is low, the counter is zero and the period code is 00.
- R2: Both bus lines pass through a two-flop synchronizer before edge detection. A start is SDA falling while SCL stays high. A stop is SDA rising while SCL stays high. A stop driven on the lines clears the watchdog output on the third rising clock edge after it is applied.
- R3: A start, then an SCL fall, then an SCL rise, then a stop restarts the watchdog. The output goes low and counting begins again from zero.
- R4: Shorter activity never restarts the watchdog. This covers a start followed directly by a stop, SCL pulses with no start, and a stop with no start before it.
- R5: A repeated start inside an open sequence keeps it open. When a sequence has already seen its clock phases, a repeated start and then a stop still restart the watchdog.
- R6: The output rises exactly N clock edges after the counter was cleared. N is PER0 for code 00, PER1 for code 01 and PER2 for code 10.
- R7: Once high, the output stays high until a valid restart, a reset or a write of code 11. Writes of other codes and incomplete bus activity leave it high.
- R8: Code 11 disables the watchdog. The output is forced low and the counter is held at zero. A later write of an active code starts a full period from zero.
- R9: A write to the period field clears the counter. The new period is timed from the write edge, not from the earlier restart.
- R10: When a restart lands on the same edge on which the timer would expire, the restart wins. The output stays low and a full new period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_i | input | 1 | Raw bus data line, observed only |
| scl_i | input | 1 | Raw bus clock line, observed only |
| cfg_we_i | input | 1 | Write strobe for the period field |
| cfg_wdata_i | input | 2 | New period code (00, 01, 10 active; 11 off) |
| wdo_o | output | 1 | Watchdog output, high once the timer has expired |

## Verification
The expiry of the timeout counter and a restart from a completed bus frame can fall on the same clock edge. That is the contention that matters here. To provoke it, the bench clears the counter with a register write at a known edge and leaves a frame open up to its clock-high phase. It then applies the stop exactly three cycles before the computed expiry edge, which matches the synchronizer-plus-detector latency. The scoreboard expects the output to stay low on that edge and to rise exactly one full period later. That result shows the restart had priority and the count began again from zero.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Progress through the minimal restart framing
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_OPEN  = 2'd1,
        FR_LOW   = 2'd2,
        FR_ARMED = 2'd3
    } frame_st_e;

    // Decoded bus events for one clock cycle
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_evt_t;

    localparam logic [1:0] SEL_RESET = 2'b00;
    localparam logic [1:0] SEL_OFF   = 2'b11;

endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
    parameter int           W        = 2,
    parameter int           STAGES   = 2,
    parameter logic [W-1:0] IDLE_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] st;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.st[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            r_d.st[i] = r_q.st[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= sync_t'({STAGES{IDLE_VAL}});
        end else begin
            r_q <= r_d;
        end
    end

    assign q_o = r_q.st[STAGES-1];

endmodule

// File: rtl/wdg_evt.sv
module wdg_evt
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sda_s,
    input  logic     scl_s,
    output bus_evt_t evt_o
);

    typedef struct packed {
        logic sda_prev;
        logic scl_prev;
    } evt_st_t;

    evt_st_t e_d, e_q;

    always_comb begin
        e_d.sda_prev = sda_s;
        e_d.scl_prev = scl_s;

        // A condition needs SCL high both before and after the SDA change
        evt_o.start    = e_q.scl_prev & scl_s & e_q.sda_prev & ~sda_s;
        evt_o.stop     = e_q.scl_prev & scl_s & ~e_q.sda_prev & sda_s;
        evt_o.scl_rise = ~e_q.scl_prev & scl_s;
        evt_o.scl_fall = e_q.scl_prev & ~scl_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{sda_prev: 1'b1, scl_prev: 1'b1};
        end else begin
            e_q <= e_d;
        end
    end

endmodule

// File: rtl/wdg_frame.sv
module wdg_frame
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_evt_t evt_i,
    output logic     restart_o
);

    typedef struct packed {
        frame_st_e st;
    } frame_t;

    frame_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        restart_o = 1'b0;
        if (evt_i.stop) begin
            // Only a sequence that has seen both clock phases counts
            restart_o = (f_q.st == FR_ARMED);
            f_d.st    = FR_IDLE;
        end else if (evt_i.start) begin
            // A repeated start keeps the sequence open and its progress
            f_d.st = (f_q.st == FR_ARMED) ? FR_ARMED : FR_OPEN;
        end else begin
            unique case (f_q.st)
                FR_OPEN:  if (evt_i.scl_fall) f_d.st = FR_LOW;
                FR_LOW:   if (evt_i.scl_rise) f_d.st = FR_ARMED;
                default:  f_d.st = f_q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{st: FR_IDLE};
        end else begin
            f_q <= f_d;
        end
    end

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int PER0 = 25000,
    parameter int PER1 = 50000,
    parameter int PER2 = 100000,
    parameter int CW   = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we_i,
    input  logic [1:0]    cfg_wdata_i,
    input  logic          restart_i,
    output logic          wdo_o,
    output logic [CW-1:0] cnt_o,
    output logic [1:0]    sel_o
);

    typedef struct packed {
        logic [1:0]    sel;
        logic [CW-1:0] cnt;
        logic          wdo;
    } tmr_t;

    tmr_t t_d, t_q;

    // Last count value before expiry for each active code
    function automatic logic [CW-1:0] last_of(logic [1:0] code);
        case (code)
            2'b00:   return CW'(PER0 - 1);
            2'b01:   return CW'(PER1 - 1);
            default: return CW'(PER2 - 1);
        endcase
    endfunction

    always_comb begin
        t_d = t_q;
        if (cfg_we_i) begin
            t_d.sel = cfg_wdata_i;
            t_d.cnt = '0;
        end
        if (restart_i) begin
            t_d.cnt = '0;
            t_d.wdo = 1'b0;
        end else if (!cfg_we_i && (t_q.sel != SEL_OFF) && !t_q.wdo) begin
            if (t_q.cnt == last_of(t_q.sel)) begin
                t_d.wdo = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt + CW'(1);
            end
        end
        if (t_d.sel == SEL_OFF) begin
            t_d.cnt = '0;
            t_d.wdo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{sel: SEL_RESET, cnt: '0, wdo: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    assign wdo_o = t_q.wdo;
    assign cnt_o = t_q.cnt;
    assign sel_o = t_q.sel;

endmodule

// File: rtl/wdg_bus_watchdog.sv
module wdg_bus_watchdog
    import wdg_pkg::*;
#(
    parameter int PER0      = 25000,
    parameter int PER1      = 50000,
    parameter int PER2      = 100000,
    parameter int SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_i,
    input  logic       scl_i,
    input  logic       cfg_we_i,
    input  logic [1:0] cfg_wdata_i,
    output logic       wdo_o
);

    localparam int PMAX01 = (PER0 > PER1) ? PER0 : PER1;
    localparam int PMAX   = (PMAX01 > PER2) ? PMAX01 : PER2;
    localparam int CW     = $clog2(PMAX + 1);

    logic [1:0]    lines_s;
    bus_evt_t      evt;
    logic          restart;
    logic [CW-1:0] count;
    logic [1:0]    period_sel;

    wdg_sync #(
        .W       (2),
        .STAGES  (SYNC_DEPTH),
        .IDLE_VAL(2'b11)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({sda_i, scl_i}),
        .q_o  (lines_s)
    );

    wdg_evt u_evt (
        .clk  (clk),
        .rst_n(rst_n),
        .sda_s(lines_s[1]),
        .scl_s(lines_s[0]),
        .evt_o(evt)
    );

    wdg_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .restart_o(restart)
    );

    wdg_timer #(
        .PER0(PER0),
        .PER1(PER1),
        .PER2(PER2),
        .CW  (CW)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we_i),
        .cfg_wdata_i(cfg_wdata_i),
        .restart_i  (restart),
        .wdo_o      (wdo_o),
        .cnt_o      (count),
        .sel_o      (period_sel)
    );

endmodule

// File: rtl/wdg_bus_watchdog_chk.sv
module wdg_bus_watchdog_chk
    import wdg_pkg::*;
#(
    parameter int CW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wdo,
    input logic          restart,
    input logic [1:0]    sel,
    input logic [CW-1:0] cnt,
    input logic          cfg_we,
    input logic [1:0]    cfg_wdata
);

    // R8: the off code keeps the output low and the counter at zero
    a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_OFF) |-> (!wdo && cnt == '0));

    // R3: a completed frame clears the output and the count
    a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!wdo && cnt == '0));

    // R7: once high, the output holds unless restarted or switched off
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wdo && !restart && !(cfg_we && cfg_wdata == SEL_OFF)) |=> wdo);

    // R9: a write always leaves the counter at zero
    a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cnt == '0));

    // R6: expiry is never caused on a restart or write edge
    a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdo) |-> $past(!restart && !cfg_we && sel != SEL_OFF));

    // R6: while running, the counter advances by one per cycle until expiry
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdo && !restart && !cfg_we && sel != SEL_OFF)
        |=> (wdo || cnt == $past(cnt) + CW'(1)));

    // R10: a restart on the expiry edge leaves the output low
    a_r10_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !$rose(wdo));

endmodule

bind wdg_bus_watchdog wdg_bus_watchdog_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdo      (wdo_o),
    .restart  (restart),
    .sel      (period_sel),
    .cnt      (count),
    .cfg_we   (cfg_we_i),
    .cfg_wdata(cfg_wdata_i)
);

// File: tb/tb_wdg_bus_watchdog.sv
module tb_wdg_bus_watchdog;

    localparam int P0  = 60;
    localparam int P1  = 120;
    localparam int P2  = 240;
    localparam int LAT = 3;   // two sync flops plus the edge-detect register

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       sda   = 1'b1;
    logic       scl   = 1'b1;
    logic       we    = 1'b0;
    logic [1:0] wd    = 2'b00;
    logic       wdo;

    int unsigned cyc    = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    typedef struct {
        int unsigned at;
        logic        val;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    wdg_bus_watchdog #(.PER0(P0), .PER1(P1), .PER2(P2)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda),
        .scl_i      (scl),
        .cfg_we_i   (we),
        .cfg_wdata_i(wd),
        .wdo_o      (wdo)
    );

    // Monitor: pop every expected item due in this cycle and compare
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                checks++;
                if (wdo !== sb[i].val) begin
                    errors++;
                    $display("FAIL %s: cycle %0d wdo=%b expected %b",
                             sb[i].tag, cyc, wdo, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    // Driver-side push: value of wdo after k more rising edges
    task automatic expect_wdo(int unsigned k, logic v, string tag);
        sb.push_back('{cyc + k, v, tag});
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus(logic d, logic c);
        sda = d;
        scl = c;
        tick(4);
    endtask

    task automatic write_cfg(logic [1:0] v);
        we = 1'b1;
        wd = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wait_until(int unsigned t);
        while (cyc < t) @(negedge clk);
    endtask

    // Start, clock low, clock high; leaves SDA low and SCL high
    task automatic open_frame();
        bus(1'b0, 1'b1);
        bus(1'b0, 1'b0);
        bus(1'b0, 1'b1);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        int unsigned c;
        int unsigned r;

        tick(3);
        // R1 / R6: reset state and expiry with code 00
        rst_n = 1'b1;
        expect_wdo(1, 1'b0, "R1");
        expect_wdo(P0 - 1, 1'b0, "R1");
        expect_wdo(P0, 1'b1, "R6");
        tick(P0 + 2);

        // R7 / R4: start immediately followed by stop leaves the output high
        expect_wdo(30, 1'b1, "R7");
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        tick(30);

        // R2 / R3: complete frame, exact latency from the stop
        open_frame();
        c = cyc;
        expect_wdo(LAT - 1, 1'b1, "R2");
        expect_wdo(LAT, 1'b0, "R3");
        expect_wdo(LAT + P0 - 1, 1'b0, "R3");
        expect_wdo(LAT + P0, 1'b1, "R6");
        sda = 1'b1;
        wait_until(c + LAT + P0 + 2);

        // R4: shorter activity within a running period does not restart
        open_frame();
        c = cyc;
        expect_wdo(LAT, 1'b0, "R4");
        expect_wdo(LAT + P0 - 1, 1'b0, "R4");
        expect_wdo(LAT + P0, 1'b1, "R4");
        sda = 1'b1;
        tick(4);
        bus(1'b0, 1'b1);    // start
        bus(1'b1, 1'b1);    // stop with no clock phases
        bus(1'b1, 1'b0);    // SCL pulse without a start
        bus(1'b1, 1'b1);
        bus(1'b1, 1'b0);    // stop with no start before it
        bus(1'b0, 1'b0);
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        wait_until(c + LAT + P0 + 2);

        // R7: a write of an active code leaves an expired output high
        expect_wdo(2, 1'b1, "R7");
        write_cfg(2'b01);
        tick(3);

        // R5: repeated start after the clock phases, then stop
        open_frame();
        bus(1'b0, 1'b0);
        bus(1'b1, 1'b0);
        bus(1'b1, 1'b1);
        bus(1'b0, 1'b1);    // repeated start
        c = cyc;
        expect_wdo(LAT, 1'b0, "R5");
        expect_wdo(LAT + P1 - 1, 1'b0, "R5");
        expect_wdo(LAT + P1, 1'b1, "R6");
        sda = 1'b1;
        wait_until(c + LAT + P1 + 2);

        // R9: a write mid-period restarts timing from the write edge
        open_frame();
        c = cyc;
        expect_wdo(LAT, 1'b0, "R9");
        sda = 1'b1;
        tick(20);
        write_cfg(2'b10);
        r = cyc;
        expect_wdo(c + LAT + P1 - r, 1'b0, "R9");
        expect_wdo(P2 - 1, 1'b0, "R9");
        expect_wdo(P2, 1'b1, "R9");
        wait_until(r + P2 + 2);

        // R8: the off code forces the output low and holds it there
        expect_wdo(1, 1'b0, "R8");
        write_cfg(2'b11);
        expect_wdo(300, 1'b0, "R8");
        tick(302);
        write_cfg(2'b00);
        expect_wdo(P0 - 1, 1'b0, "R8");
        expect_wdo(P0, 1'b1, "R8");
        tick(P0 + 2);

        // R10: restart lands on the expiry edge
        open_frame();
        sda = 1'b1;
        tick(4);
        write_cfg(2'b00);
        r = cyc;
        open_frame();
        wait_until(r + P0 - LAT);
        expect_wdo(LAT, 1'b0, "R10");
        expect_wdo(LAT + P0 - 1, 1'b0, "R10");
        expect_wdo(LAT + P0, 1'b1, "R10");
        sda = 1'b1;
        tick(4);

        while (sb.size() > 0 && cyc < r + 4 * P2) tick(1);
        foreach (sb[i]) begin
            checks++;
            errors++;
            $display("FAIL %s: item for cycle %0d never sampled, expected %b",
                     sb[i].tag, sb[i].at, sb[i].val);
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung, expected completion");
            summary();
            $finish;
        end
    end

endmodule